// File: doc/BRIEF.md
# Receive Error-Bit Policy for a Single-Wire Consumer-Control Bus

This block sits next to the receive bit decoder of a single-wire, open-drain consumer-electronics control bus. The decoder reports three kinds of timing fault as one-cycle pulses:

- a rising edge of the line at the wrong time;
- a bit period that ran too long;
- a bit period that ended too early.

The block also receives a flag that says the frame now on the wire is a broadcast, a flag for full listening (snooping traffic for other addresses), and four static configuration bits. From these it decides two things for each fault. The first is whether the current reception must be abandoned, shown as a one-cycle `rx_abort` strobe. The second is whether an error bit must be forced onto the bus, shown as `drive_low`, an enable for the open-drain pull-down.

The error bit is a low pulse lasting `ERR_TICKS` pulses of `bit_tick`. With the default of 3 and a tick every half nominal bit, that is one and a half bit periods.

Only one error bit is sent per message. After one has been sent, the block waits for the decoder's `msg_start` pulse before it will send another. The controller is a three-state machine:

- `ST_IDLE`: no error bit sent in this message yet.
- `ST_DRIVE`: pulling the line low.
- `ST_SPENT`: an error bit was already sent for this message.

Its transitions are:

- `ST_IDLE` to `ST_DRIVE` when a fault calls for an error bit.
- `ST_DRIVE` to `ST_SPENT` when the `ERR_TICKS`-th tick arrives while driving.
- `ST_SPENT` to `ST_IDLE` on `msg_start`.

In every other case the state holds.

Top module: `cec_err_policy`

## Requirements
- R1: After reset `drive_low` and `rx_abort` are 0 and the machine is in `ST_IDLE`.
- R2: A rising-edge fault with `cfg_stop_on_rise`=1 gives `rx_abort`=1 for exactly one cycle, starting in the cycle after the fault is sampled. With `cfg_stop_on_rise`=0 a rising-edge fault that sends no error bit gives no `rx_abort`.
- R3: For a non-broadcast frame (`bcast`=0), a rising-edge fault sends an error bit only when `cfg_stop_on_rise`=1 and `cfg_rise_gen`=1.
- R4: For a non-broadcast frame, a long-period fault sends an error bit exactly when `cfg_long_gen`=1.
- R5: For a broadcast frame (`bcast`=1) with `cfg_bcast_quiet`=0, a rising-edge fault sends an error bit whenever `cfg_stop_on_rise`=1, whatever the value of `cfg_rise_gen`. A long-period fault sends an error bit whatever the value of `cfg_long_gen`.
- R6: For a broadcast frame with `cfg_bcast_quiet`=1, neither a rising-edge fault nor a long-period fault sends an error bit. A rising-edge fault with `cfg_stop_on_rise`=1 still raises `rx_abort`.
- R7: A short-period fault sends an error bit, except for a broadcast frame while `listen_all`=1, where it sends none.
- R8: `drive_low` rises in the cycle after the triggering fault is sampled. It stays high until the cycle after the `ERR_TICKS`-th `bit_tick` is sampled while driving.
- R9: At most one error bit is sent per message. Faults while driving, and faults after the error bit until the next `msg_start`, send no error bit. A `msg_start` seen while driving is ignored.
- R10: Every start of an error bit also raises `rx_abort` in the same cycle that `drive_low` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Timebase pulse, one per half nominal bit by default |
| msg_start | input | 1 | Pulse at the start of each received message |
| err_rise | input | 1 | Rising-edge timing fault pulse |
| err_long | input | 1 | Long bit period fault pulse |
| err_short | input | 1 | Short bit period fault pulse |
| bcast | input | 1 | Current frame is a broadcast |
| listen_all | input | 1 | Full listening mode active |
| cfg_stop_on_rise | input | 1 | A rising-edge fault abandons reception |
| cfg_rise_gen | input | 1 | A rising-edge fault may send an error bit |
| cfg_long_gen | input | 1 | A long-period fault sends an error bit |
| cfg_bcast_quiet | input | 1 | Suppress error bits for broadcast rising-edge and long-period faults |
| rx_abort | output | 1 | One-cycle reception-abort strobe |
| drive_low | output | 1 | Open-drain pull-down enable for the error bit |

## Verification
The assertions check on every cycle the properties that relate ports from one cycle to the next:

- a broadcast with the quiet option never starts an error bit from a rising-edge or long-period fault;
- a broadcast short-period fault under full listening never starts one;
- a rising-edge fault with stop disabled does nothing;
- the pull-down never releases without a tick;
- an error bit never restarts in the cycle after one ends;
- every error bit's rise carries an abort.

The exact pulse length in ticks can only be shown by the bench's directed scenarios, which count the ticks. The same holds for the full policy table across configuration combinations, and for the once-per-message lockout, including the ignored `msg_start`.

// File: rtl/cec_err_policy_pkg.sv
package cec_err_policy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_SPENT = 2'd2
    } ebp_state_e;

    typedef struct packed {
        logic rise;
        logic long_p;
        logic short_p;
    } ebp_faults_t;

    typedef struct packed {
        logic stop_on_rise;
        logic rise_gen;
        logic long_gen;
        logic bcast_quiet;
    } ebp_cfg_t;

endpackage

// File: rtl/cec_err_decide.sv
module cec_err_decide
    import cec_err_policy_pkg::*;
(
    input  ebp_faults_t faults,
    input  ebp_cfg_t    cfg,
    input  logic        bcast,
    input  logic        listen_all,
    output logic        want_bit,
    output logic        want_stop
);
    logic rise_ok, long_ok, short_ok;

    always_comb begin
        // Per-fault permission; the broadcast path overrides the per-fault bits.
        if (bcast) begin
            rise_ok = !cfg.bcast_quiet && cfg.stop_on_rise;
            long_ok = !cfg.bcast_quiet;
        end else begin
            rise_ok = cfg.stop_on_rise && cfg.rise_gen;
            long_ok = cfg.long_gen;
        end
        short_ok  = !(bcast && listen_all);
        want_bit  = (faults.rise    && rise_ok)
                  | (faults.long_p  && long_ok)
                  | (faults.short_p && short_ok);
        want_stop = faults.rise && cfg.stop_on_rise;
    end
endmodule

// File: rtl/cec_err_timer.sv
module cec_err_timer #(
    parameter int ERR_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (ERR_TICKS > 1) ? $clog2(ERR_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ERR_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run)       cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + CW'(1);
    end

    assign expire = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/cec_err_policy.sv
module cec_err_policy
    import cec_err_policy_pkg::*;
#(
    parameter int ERR_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic msg_start,
    input  logic err_rise,
    input  logic err_long,
    input  logic err_short,
    input  logic bcast,
    input  logic listen_all,
    input  logic cfg_stop_on_rise,
    input  logic cfg_rise_gen,
    input  logic cfg_long_gen,
    input  logic cfg_bcast_quiet,
    output logic rx_abort,
    output logic drive_low
);
    ebp_state_e  state_q, state_d;
    ebp_faults_t faults;
    ebp_cfg_t    cfg;
    logic        want_bit, want_stop, expire, start_emit, abort_q;

    assign faults = '{rise: err_rise, long_p: err_long, short_p: err_short};
    assign cfg    = '{stop_on_rise: cfg_stop_on_rise, rise_gen: cfg_rise_gen,
                      long_gen: cfg_long_gen, bcast_quiet: cfg_bcast_quiet};

    cec_err_decide u_decide (
        .faults    (faults),
        .cfg       (cfg),
        .bcast     (bcast),
        .listen_all(listen_all),
        .want_bit  (want_bit),
        .want_stop (want_stop)
    );

    cec_err_timer #(.ERR_TICKS(ERR_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_DRIVE),
        .tick  (bit_tick),
        .expire(expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (want_bit)  state_d = ST_DRIVE;
            ST_DRIVE: if (expire)    state_d = ST_SPENT;
            ST_SPENT: if (msg_start) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign start_emit = (state_q == ST_IDLE) && want_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= want_stop || start_emit;
    end

    always_comb begin
        drive_low = (state_q == ST_DRIVE);
        rx_abort  = abort_q;
    end
endmodule

// File: rtl/cec_err_policy_chk.sv
module cec_err_policy_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic err_rise,
    input logic err_long,
    input logic err_short,
    input logic bcast,
    input logic listen_all,
    input logic cfg_stop_on_rise,
    input logic cfg_bcast_quiet,
    input logic rx_abort,
    input logic drive_low
);
    p_abort_on_emit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> rx_abort);

    p_quiet_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_low && bcast && cfg_bcast_quiet && !err_short) |=> !drive_low);

    p_short_listen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_low && bcast && listen_all && !err_rise && !err_long) |=> !drive_low);

    p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && !bit_tick) |=> drive_low);

    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |=> !drive_low);

    p_rise_nostop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_low && !bcast && !cfg_stop_on_rise && !err_long && !err_short)
        |=> (!drive_low && !rx_abort));
endmodule

bind cec_err_policy cec_err_policy_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bit_tick        (bit_tick),
    .err_rise        (err_rise),
    .err_long        (err_long),
    .err_short       (err_short),
    .bcast           (bcast),
    .listen_all      (listen_all),
    .cfg_stop_on_rise(cfg_stop_on_rise),
    .cfg_bcast_quiet (cfg_bcast_quiet),
    .rx_abort        (rx_abort),
    .drive_low       (drive_low)
);

// File: tb/cec_err_policy_test.sv
`timescale 1ns/1ps
module cec_err_policy_test;
    localparam int NT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, msg_start = 0, err_rise = 0, err_long = 0, err_short = 0;
    logic bcast = 0, listen_all = 0;
    logic cfg_stop_on_rise = 0, cfg_rise_gen = 0, cfg_long_gen = 0, cfg_bcast_quiet = 0;
    logic rx_abort, drive_low;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    cec_err_policy #(.ERR_TICKS(NT)) uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .msg_start(msg_start),
        .err_rise(err_rise), .err_long(err_long), .err_short(err_short),
        .bcast(bcast), .listen_all(listen_all),
        .cfg_stop_on_rise(cfg_stop_on_rise), .cfg_rise_gen(cfg_rise_gen),
        .cfg_long_gen(cfg_long_gen), .cfg_bcast_quiet(cfg_bcast_quiet),
        .rx_abort(rx_abort), .drive_low(drive_low)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic s, input logic rg, input logic lg, input logic q,
                           input logic b, input logic la);
        @(negedge clk);
        cfg_stop_on_rise = s; cfg_rise_gen = rg; cfg_long_gen = lg;
        cfg_bcast_quiet = q; bcast = b; listen_all = la;
    endtask

    // Pulse faults for one cycle; afterwards outputs reflect that edge.
    task automatic fire(input logic r, input logic l, input logic sh);
        @(negedge clk);
        err_rise = r; err_long = l; err_short = sh;
        @(negedge clk);
        err_rise = 0; err_long = 0; err_short = 0;
    endtask

    task automatic tick1;
        @(negedge clk); bit_tick = 1;
        @(negedge clk); bit_tick = 0;
    endtask

    task automatic new_msg;
        @(negedge clk); msg_start = 1;
        @(negedge clk); msg_start = 0;
    endtask

    task automatic settle;
        for (int i = 0; i < NT; i++) tick1();
        new_msg();
    endtask

    // Fire and check both outputs right after the sampling edge.
    task automatic expect_fire(input string tag, input logic r, input logic l, input logic sh,
                               input logic exp_ab, input logic exp_dl);
        fire(r, l, sh);
        chk({tag, " rx_abort"}, rx_abort, exp_ab);
        chk({tag, " drive_low"}, drive_low, exp_dl);
        settle();
    endtask

    task automatic t_reset;
        chk("R1 rx_abort at reset", rx_abort, 1'b0);
        chk("R1 drive_low at reset", drive_low, 1'b0);
    endtask

    task automatic t_rise_policy;
        set_cfg(0, 0, 0, 0, 0, 0); expect_fire("R2 R3 nostop nogen", 1, 0, 0, 0, 0);
        set_cfg(0, 1, 0, 0, 0, 0); expect_fire("R2 R3 nostop gen", 1, 0, 0, 0, 0);
        set_cfg(1, 0, 0, 0, 0, 0); expect_fire("R2 R3 stop nogen", 1, 0, 0, 1, 0);
        set_cfg(1, 1, 0, 0, 0, 0); expect_fire("R3 R10 stop gen", 1, 0, 0, 1, 1);
        set_cfg(1, 0, 0, 0, 0, 0);
        fire(1, 0, 0);
        @(negedge clk);
        chk("R2 abort one cycle", rx_abort, 1'b0);
        settle();
    endtask

    task automatic t_long_policy;
        set_cfg(0, 0, 0, 0, 0, 0); expect_fire("R4 long nogen", 0, 1, 0, 0, 0);
        set_cfg(0, 0, 1, 0, 0, 0); expect_fire("R4 R10 long gen", 0, 1, 0, 1, 1);
    endtask

    task automatic t_bcast_loud;
        set_cfg(1, 0, 0, 0, 1, 0); expect_fire("R5 bcast rise stop", 1, 0, 0, 1, 1);
        set_cfg(0, 1, 0, 0, 1, 0); expect_fire("R5 bcast rise nostop", 1, 0, 0, 0, 0);
        set_cfg(0, 0, 0, 0, 1, 0); expect_fire("R5 bcast long nogen", 0, 1, 0, 1, 1);
    endtask

    task automatic t_bcast_quiet;
        set_cfg(1, 1, 1, 1, 1, 0); expect_fire("R6 quiet rise", 1, 0, 0, 1, 0);
        set_cfg(0, 0, 1, 1, 1, 0); expect_fire("R6 quiet long", 0, 1, 0, 0, 0);
    endtask

    task automatic t_short;
        set_cfg(0, 0, 0, 0, 0, 1); expect_fire("R7 short unicast listen", 0, 0, 1, 1, 1);
        set_cfg(0, 0, 0, 0, 1, 0); expect_fire("R7 short bcast", 0, 0, 1, 1, 1);
        set_cfg(0, 0, 0, 0, 1, 1); expect_fire("R7 short bcast listen", 0, 0, 1, 0, 0);
    endtask

    task automatic t_duration;
        set_cfg(0, 0, 1, 0, 0, 0);
        fire(0, 1, 0);
        chk("R8 low after fault", drive_low, 1'b1);
        for (int i = 0; i < NT - 1; i++) begin
            tick1();
            chk("R8 still low", drive_low, 1'b1);
        end
        repeat (4) @(negedge clk);
        chk("R8 held without tick", drive_low, 1'b1);
        tick1();
        chk("R8 release on last tick", drive_low, 1'b0);
        new_msg();
    endtask

    task automatic t_once;
        set_cfg(0, 0, 1, 0, 0, 0);
        fire(0, 1, 0);
        chk("R9 first emit", drive_low, 1'b1);
        tick1();
        fire(0, 1, 0);
        chk("R9 fault while driving no abort", rx_abort, 1'b0);
        new_msg();
        for (int i = 0; i < NT - 2; i++) tick1();
        chk("R9 not extended", drive_low, 1'b1);
        tick1();
        chk("R9 ends on schedule", drive_low, 1'b0);
        fire(0, 1, 0);
        chk("R9 locked after ignored msg_start", drive_low, 1'b0);
        new_msg();
        fire(0, 1, 0);
        chk("R9 rearmed by msg_start", drive_low, 1'b1);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_rise_policy();
        t_long_policy();
        t_bcast_loud();
        t_bcast_quiet();
        t_short();
        t_duration();
        t_once();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule